// File: doc/BRIEF.md
# Read Prefetch Limit Controller

This block sits in the read path of a bus bridge. When a read request is accepted, it works out how many DWORDs may be fetched ahead from the target. The limit depends on the command type, on whether the address space is prefetchable, on the cache line size setting, and on whether the bridge runs in flow-through mode. The limit runs from the request's start address up to the next aligned block boundary. A start address that already sits on a boundary fetches one full block.

After a request is loaded, the block counts the DWORDs that come back from the target. It ends prefetching when the count reaches the limit, when the target disconnects, when the initiator ends the transaction, or, in flow-through mode only, when the initiator drops its frame signal. On the delivery side it counts the DWORDs handed to the initiator. It flags the transfer that carries the final fetched DWORD, so that a disconnect can be returned with that transfer. If the initiator leaves early, it reports how many fetched DWORDs are discarded. Bus signalling and data storage live elsewhere.

Top module: `pf_boundary_ctrl`

## Requirements
- R1: Command codes on `rd_cmd` are 0 configuration read, 1 I/O read, 2 memory read, 3 memory read line, 4 memory read multiple. Codes 0, 1 and the unused codes 5 to 7 always give a fetch limit of exactly one DWORD.
- R2: A memory read (code 2) with `pref_space` = 0 gives a limit of one DWORD.
- R3: A memory read with `pref_space` = 1, and a memory read line whatever `pref_space` is, use a block of `line_size` DWORDs when `line_size` is 1, 2, 4, 8 or 16. Any other `line_size` value, 0 included, gives a block of 16. The limit is block − (start_addr mod block).
- R4: A memory read multiple uses twice the block of R3: 2×`line_size` for 1, 2, 4, 8 or 16, and 32 otherwise. The limit follows the formula of R3.
- R5: With `flow_mode` = 1, commands 2 (prefetchable only), 3 and 4 use a block of PAGE_DW DWORDs (default 1024, 4 KB). Non-prefetching reads stay at one DWORD.
- R6: `fetch_limit` is valid the cycle after `start`, and `fetch_cnt` starts at 0. Each `fetch_vld` cycle adds one. In the cycle after the count reaches the limit, `fetch_stop` is high for exactly one cycle and `pf_run` is low.
- R7: `tgt_disc` ends prefetching at once. A `fetch_vld` in the same cycle is still counted, and `fetch_vld` after the stop leaves `fetch_cnt` unchanged.
- R8: In flow-through mode on a prefetching command, `ini_frame` = 0 ends prefetching the same way as R7. Outside flow-through mode `ini_frame` has no effect.
- R9: Once prefetching has stopped, `last_dw` is high in the same cycle as the `xfer_vld` that delivers the final fetched DWORD, and in no other cycle. `busy` is low the following cycle.
- R10: `ini_end` with DWORDs still undelivered ends the session. In the next cycle `discard` pulses and `drop_cnt` equals fetched minus delivered, counting any `xfer_vld` in the same cycle.
- R11: After reset `busy`, `pf_run`, `fetch_limit`, `fetch_cnt`, `fetch_stop`, `last_dw`, `discard` and `drop_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a new read request |
| rd_cmd | input | 3 | Read command code |
| pref_space | input | 1 | Address lies in prefetchable space |
| line_size | input | 8 | Cache line size in DWORDs |
| start_addr | input | ADDR_W | Starting DWORD address |
| flow_mode | input | 1 | Flow-through mode |
| ini_frame | input | 1 | Initiator frame still asserted (active high) |
| tgt_disc | input | 1 | Target disconnect seen |
| fetch_vld | input | 1 | One DWORD fetched from the target |
| xfer_vld | input | 1 | One DWORD delivered to the initiator |
| ini_end | input | 1 | Initiator ended the transaction |
| busy | output | 1 | A request session is open |
| pf_run | output | 1 | Prefetching is in progress |
| fetch_limit | output | CNT_W | DWORD limit for the current request |
| fetch_cnt | output | CNT_W | DWORDs fetched so far |
| fetch_stop | output | 1 | One-cycle pulse when prefetching ends |
| last_dw | output | 1 | Current transfer carries the final DWORD; return disconnect |
| discard | output | 1 | One-cycle pulse when leftover data is dropped |
| drop_cnt | output | CNT_W | Number of DWORDs dropped |

## Verification
The assertions rest on three assumptions about the inputs. `fetch_vld` arrives only while `pf_run` is high. `xfer_vld` does not run ahead of the fetched count. `ini_end` never coincides with a `fetch_vld`. The bench drives fetch strobes only up to the computed limit or a stop, and delivers only DWORDs that have already been fetched. It raises `ini_end` only in cycles with no fetch activity. Any strobes it sends after a stop are deliberate probes of R7.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [2:0] {
        RD_CFG  = 3'd0,
        RD_IO   = 3'd1,
        RD_MEM  = 3'd2,
        RD_LINE = 3'd3,
        RD_MULT = 3'd4
    } rd_cmd_e;

    typedef struct packed {
        logic [2:0] cmd;
        logic       pref;
        logic [7:0] cls;
        logic       flow;
    } rd_req_t;

    // True when the command is allowed to read ahead at all.
    function automatic logic may_prefetch(input logic [2:0] cmd, input logic pref);
        return (cmd == RD_LINE) || (cmd == RD_MULT) || ((cmd == RD_MEM) && pref);
    endfunction

    // log2 of the aligned block size in DWORDs; 0 means a single DWORD.
    function automatic logic [4:0] blk_log2(input rd_req_t req, input logic [4:0] page_lg);
        logic [4:0] lg;
        logic       line_ok;
        line_ok = 1'b1;
        case (req.cls)
            8'd1:    lg = 5'd0;
            8'd2:    lg = 5'd1;
            8'd4:    lg = 5'd2;
            8'd8:    lg = 5'd3;
            8'd16:   lg = 5'd4;
            default: begin lg = 5'd4; line_ok = 1'b0; end
        endcase
        if (!line_ok) lg = 5'd4;
        if (!may_prefetch(req.cmd, req.pref)) begin
            lg = 5'd0;
        end else if (req.flow) begin
            lg = page_lg;
        end else if (req.cmd == RD_MULT) begin
            lg = lg + 5'd1;
        end
        return lg;
    endfunction

endpackage

// File: rtl/pf_limit_calc.sv
module pf_limit_calc
    import pf_pkg::*;
#(
    parameter int ADDR_W  = 30,
    parameter int PAGE_LG = 10,
    parameter int CNT_W   = PAGE_LG + 1
) (
    input  rd_req_t           req,
    input  logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  limit
);
    logic [4:0]       lg;
    logic [CNT_W-1:0] blk;
    logic [CNT_W-1:0] off;

    always_comb begin
        lg    = blk_log2(req, 5'(PAGE_LG));
        blk   = CNT_W'(1) << lg;
        off   = CNT_W'(addr[PAGE_LG-1:0]) & (blk - CNT_W'(1));
        limit = blk - off;
    end
endmodule

// File: rtl/pf_fetch_ctr.sv
module pf_fetch_ctr #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             fetch_vld,
    input  logic             tgt_disc,
    input  logic             frame_stop_en,
    input  logic             ini_frame,
    input  logic             abort,
    output logic [CNT_W-1:0] limit_q,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             stop_pulse
);
    logic [CNT_W-1:0] cnt_nx;
    logic             halt;

    always_comb begin
        cnt_nx = cnt + CNT_W'(fetch_vld);
        halt   = (cnt_nx == limit_q) || tgt_disc || abort
               || (frame_stop_en && !ini_frame);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q    <= '0;
            cnt        <= '0;
            running    <= 1'b0;
            stop_pulse <= 1'b0;
        end else begin
            stop_pulse <= 1'b0;
            if (load) begin
                limit_q <= limit_in;
                cnt     <= '0;
                running <= 1'b1;
            end else if (running) begin
                cnt <= cnt_nx;
                if (halt) begin
                    running    <= 1'b0;
                    stop_pulse <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pf_dlv_track.sv
module pf_dlv_track #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             active,
    input  logic             fetch_done,
    input  logic [CNT_W-1:0] fetch_cnt,
    input  logic             xfer_vld,
    input  logic             ini_end,
    output logic             last_dw,
    output logic             discard,
    output logic [CNT_W-1:0] drop_cnt,
    output logic             end_sess
);
    logic [CNT_W-1:0] dlv_cnt;
    logic [CNT_W-1:0] dlv_nx;
    logic [CNT_W-1:0] left;
    logic             take;

    always_comb begin
        take     = active && xfer_vld && (dlv_cnt < fetch_cnt);
        dlv_nx   = dlv_cnt + CNT_W'(take);
        left     = fetch_cnt - dlv_nx;
        last_dw  = take && fetch_done && (dlv_nx == fetch_cnt);
        end_sess = active && (last_dw || ini_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dlv_cnt  <= '0;
            discard  <= 1'b0;
            drop_cnt <= '0;
        end else begin
            discard <= 1'b0;
            if (load) begin
                dlv_cnt  <= '0;
                drop_cnt <= '0;
            end else if (active) begin
                dlv_cnt <= dlv_nx;
                if (ini_end && !last_dw && (left != '0)) begin
                    discard  <= 1'b1;
                    drop_cnt <= left;
                end
            end
        end
    end
endmodule

// File: rtl/pf_boundary_ctrl.sv
module pf_boundary_ctrl
    import pf_pkg::*;
#(
    parameter int ADDR_W  = 30,
    parameter int PAGE_DW = 1024,
    localparam int PAGE_LG = $clog2(PAGE_DW),
    localparam int CNT_W   = PAGE_LG + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        rd_cmd,
    input  logic              pref_space,
    input  logic [7:0]        line_size,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              flow_mode,
    input  logic              ini_frame,
    input  logic              tgt_disc,
    input  logic              fetch_vld,
    input  logic              xfer_vld,
    input  logic              ini_end,
    output logic              busy,
    output logic              pf_run,
    output logic [CNT_W-1:0]  fetch_limit,
    output logic [CNT_W-1:0]  fetch_cnt,
    output logic              fetch_stop,
    output logic              last_dw,
    output logic              discard,
    output logic [CNT_W-1:0]  drop_cnt
);
    rd_req_t          req;
    logic [CNT_W-1:0] limit_new;
    logic             fstop_en_q;
    logic             end_sess;

    always_comb begin
        req.cmd  = rd_cmd;
        req.pref = pref_space;
        req.cls  = line_size;
        req.flow = flow_mode;
    end

    pf_limit_calc #(
        .ADDR_W (ADDR_W),
        .PAGE_LG(PAGE_LG),
        .CNT_W  (CNT_W)
    ) u_lim (
        .req  (req),
        .addr (start_addr),
        .limit(limit_new)
    );

    pf_fetch_ctr #(.CNT_W(CNT_W)) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .load         (start),
        .limit_in     (limit_new),
        .fetch_vld    (fetch_vld),
        .tgt_disc     (tgt_disc),
        .frame_stop_en(fstop_en_q),
        .ini_frame    (ini_frame),
        .abort        (busy && ini_end),
        .limit_q      (fetch_limit),
        .cnt          (fetch_cnt),
        .running      (pf_run),
        .stop_pulse   (fetch_stop)
    );

    pf_dlv_track #(.CNT_W(CNT_W)) u_dlv (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .active    (busy),
        .fetch_done(!pf_run),
        .fetch_cnt (fetch_cnt),
        .xfer_vld  (xfer_vld),
        .ini_end   (ini_end),
        .last_dw   (last_dw),
        .discard   (discard),
        .drop_cnt  (drop_cnt),
        .end_sess  (end_sess)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            fstop_en_q <= 1'b0;
        end else if (start) begin
            busy       <= 1'b1;
            fstop_en_q <= flow_mode && may_prefetch(rd_cmd, pref_space);
        end else if (end_sess) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/pf_boundary_chk.sv
module pf_boundary_chk #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [2:0]       rd_cmd,
    input logic             xfer_vld,
    input logic             busy,
    input logic             pf_run,
    input logic [CNT_W-1:0] fetch_limit,
    input logic [CNT_W-1:0] fetch_cnt,
    input logic             fetch_stop,
    input logic             last_dw,
    input logic             discard,
    input logic [CNT_W-1:0] drop_cnt
);
    assert_single_dw_R1: assert property (@(posedge clk) disable iff (rst)
        start && (rd_cmd == 3'd0 || rd_cmd == 3'd1) |=> fetch_limit == CNT_W'(1));

    assert_limit_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> fetch_limit != '0);

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> fetch_cnt <= fetch_limit);

    assert_stop_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        fetch_stop |=> !fetch_stop);

    assert_stop_drops_run_R6: assert property (@(posedge clk) disable iff (rst)
        fetch_stop |-> !pf_run);

    assert_cnt_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        !pf_run && !start |=> $stable(fetch_cnt));

    assert_last_with_xfer_R9: assert property (@(posedge clk) disable iff (rst)
        last_dw |-> xfer_vld && !pf_run);

    assert_last_closes_R9: assert property (@(posedge clk) disable iff (rst)
        last_dw && !start |=> !busy);

    assert_drop_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
        discard |-> drop_cnt != '0);
endmodule

bind pf_boundary_ctrl pf_boundary_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_pf_boundary_ctrl.sv
module sim_pf_boundary_ctrl;
    localparam int ADDR_W = 30;
    localparam int CNT_W  = 11;

    logic              clk = 1'b0;
    logic              rst;
    logic              start, pref_space, flow_mode, ini_frame, tgt_disc;
    logic              fetch_vld, xfer_vld, ini_end;
    logic [2:0]        rd_cmd;
    logic [7:0]        line_size;
    logic [ADDR_W-1:0] start_addr;
    logic              busy, pf_run, fetch_stop, last_dw, discard;
    logic [CNT_W-1:0]  fetch_limit, fetch_cnt, drop_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pf_boundary_ctrl #(.ADDR_W(ADDR_W), .PAGE_DW(1024)) u0 (
        .clk(clk), .rst(rst), .start(start), .rd_cmd(rd_cmd), .pref_space(pref_space),
        .line_size(line_size), .start_addr(start_addr), .flow_mode(flow_mode),
        .ini_frame(ini_frame), .tgt_disc(tgt_disc), .fetch_vld(fetch_vld),
        .xfer_vld(xfer_vld), .ini_end(ini_end), .busy(busy), .pf_run(pf_run),
        .fetch_limit(fetch_limit), .fetch_cnt(fetch_cnt), .fetch_stop(fetch_stop),
        .last_dw(last_dw), .discard(discard), .drop_cnt(drop_cnt)
    );

    function automatic int exp_lim(int cmd, int pref, int cls, int addr, int flow);
        int blk;
        bit pf;
        pf = (cmd == 3) || (cmd == 4) || (cmd == 2 && pref != 0);
        if (!pf) return 1;
        if (flow != 0) blk = 1024;
        else begin
            if (cls == 1 || cls == 2 || cls == 4 || cls == 8 || cls == 16) blk = cls;
            else blk = 16;
            if (cmd == 4) blk = blk * 2;
        end
        return blk - (addr % blk);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic begin_req(int cmd, int pref, int cls, int addr, int flow);
        @(negedge clk);
        start = 1'b1; rd_cmd = 3'(cmd); pref_space = pref[0]; line_size = 8'(cls);
        start_addr = ADDR_W'(addr); flow_mode = flow[0];
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic fetch_n(int n);
        for (int i = 0; i < n; i++) begin
            fetch_vld = 1'b1;
            @(negedge clk);
        end
        fetch_vld = 1'b0;
    endtask

    task automatic close_session();
        ini_end = 1'b1;
        @(negedge clk);
        ini_end = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int addrs [8] = '{0, 3, 7, 13, 17, 31, 1029, 4095};
        int clss  [8] = '{0, 1, 2, 4, 8, 16, 3, 32};
        int lim;
        rst = 1'b1; start = 0; rd_cmd = 0; pref_space = 0; line_size = 0; start_addr = 0;
        flow_mode = 0; ini_frame = 1; tgt_disc = 0; fetch_vld = 0; xfer_vld = 0; ini_end = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 busy", busy, 0);       check("R11 pf_run", pf_run, 0);
        check("R11 limit", fetch_limit, 0); check("R11 cnt", fetch_cnt, 0);
        check("R11 stop", fetch_stop, 0); check("R11 last", last_dw, 0);
        check("R11 discard", discard, 0); check("R11 drop", drop_cnt, 0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5: limit sweep; full fetch/delivery (R6 R9) outside flow-through
        for (int c = 0; c < 8; c++)
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < 8; k++)
                    for (int a = 0; a < 8; a++)
                        for (int f = 0; f < 2; f++) begin
                            lim = exp_lim(c, p, clss[k], addrs[a], f);
                            begin_req(c, p, clss[k], addrs[a], f);
                            check(c < 2 || c > 4 ? "R1 limit" : (c == 2 && p == 0 ? "R2 limit" :
                                  (f == 1 ? "R5 limit" : (c == 4 ? "R4 limit" : "R3 limit"))),
                                  fetch_limit, lim);
                            if (f == 0) begin
                                check("R6 cnt at start", fetch_cnt, 0);
                                fetch_n(lim);
                                check("R6 cnt at limit", fetch_cnt, lim);
                                check("R6 stop pulse", fetch_stop, 1);
                                check("R6 run low", pf_run, 0);
                                @(negedge clk);
                                check("R6 stop one cycle", fetch_stop, 0);
                                for (int d = 0; d < lim; d++) begin
                                    xfer_vld = 1'b1;
                                    #1;
                                    check("R9 last flag", last_dw, (d == lim - 1) ? 1 : 0);
                                    @(negedge clk);
                                end
                                xfer_vld = 1'b0;
                                check("R9 session closed", busy, 0);
                            end else begin
                                close_session();
                            end
                        end

        // R7 target disconnect, same-cycle fetch counted, later fetches ignored
        begin_req(3, 0, 0, 0, 0);
        fetch_n(5);
        fetch_vld = 1'b1; tgt_disc = 1'b1;
        @(negedge clk);
        fetch_vld = 1'b0; tgt_disc = 1'b0;
        check("R7 stop on disconnect", fetch_stop, 1);
        check("R7 cnt", fetch_cnt, 6);
        fetch_n(3);
        check("R7 fetch after stop ignored", fetch_cnt, 6);
        check("R7 run low", pf_run, 0);
        close_session();

        // R8 flow-through frame drop stops
        begin_req(3, 0, 0, 0, 1);
        check("R5 flow limit aligned", fetch_limit, 1024);
        fetch_n(10);
        ini_frame = 1'b0;
        @(negedge clk);
        ini_frame = 1'b1;
        check("R8 flow frame stop", fetch_stop, 1);
        check("R8 flow cnt", fetch_cnt, 10);
        close_session();

        // R8 frame ignored outside flow-through
        begin_req(3, 0, 4, 1, 0);
        fetch_n(1);
        ini_frame = 1'b0;
        @(negedge clk);
        ini_frame = 1'b1;
        check("R8 frame ignored run", pf_run, 1);
        check("R8 frame ignored stop", fetch_stop, 0);
        fetch_n(2);
        check("R8 normal stop", fetch_stop, 1);
        check("R8 normal cnt", fetch_cnt, 3);
        close_session();

        // R10 early initiator end with same-cycle transfer
        begin_req(4, 0, 8, 0, 0);
        fetch_n(16);
        for (int d = 0; d < 5; d++) begin
            xfer_vld = 1'b1;
            @(negedge clk);
        end
        ini_end = 1'b1; xfer_vld = 1'b1;
        @(negedge clk);
        ini_end = 1'b0; xfer_vld = 1'b0;
        check("R10 discard pulse", discard, 1);
        check("R10 drop count", drop_cnt, 10);
        check("R10 session closed", busy, 0);
        @(negedge clk);
        check("R10 discard one cycle", discard, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule